// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives a baud-rate clock from one of three candidate source clocks by dividing the chosen source by a programmable ratio between 1 and 4096. All logic runs on a single fast system clock. The block synchronizes every source to that clock and counts both rising and falling edges of the selected source. Each counted edge is half a source period. A 12-bit down counter is preset from the divide value and steps down once per counted edge. When it is already at zero on a counted edge, it reloads and the output toggles. Because edges of both polarities are counted, an odd ratio places one output toggle in the low phase of the source and the next in the high phase. The output therefore keeps an exact 50% duty cycle for every ratio.

Software drives the block through four control inputs: a soft reset, a count enable, a 2-bit source select and the 12-bit divide value. A controller with three named states sequences the divider:

- RESET is entered on system reset or while the soft reset is high. The output is forced high and the counter is preset.
- RUN counts edges.
- HOLD freezes both the counter and the output.

The transitions are:

- RESET to RUN when the soft reset clears with counting allowed.
- RESET to HOLD when the soft reset clears with counting not allowed.
- RUN to HOLD when the enable drops or the reserved source code is selected.
- HOLD to RUN when both conditions clear.
- Any state to RESET whenever the soft reset is high.

Top module: `baud_gen`

## Requirements
- R1: While the system reset or the soft reset is asserted, the output is held high and no counting happens.
- R2: With divide value N (0 to 4095), the output period equals 2*(N+1) half-periods of the selected source, that is, a division by N+1.
- R3: The output high time and low time are each exactly N+1 source half-periods, for both odd and even N+1.
- R4: Source select code 0 picks the internal source, code 1 picks the first external source, and code 2 picks the second external source.
- R5: Source select code 3 is reserved. While it is selected, the output holds its level and the counter does not move.
- R6: With the count enable low, the output holds its level. Once the enable is set again, the output resumes at the programmed rate.
- R7: A new divide value written while counting does not change the half-period in progress. It is first used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all sources |
| rst_n | input | 1 | Active-low system reset |
| src_int_i | input | 1 | Internal source clock (select code 0) |
| src_ext1_i | input | 1 | First external source clock (select code 1) |
| src_ext2_i | input | 1 | Second external source clock (select code 2) |
| soft_rst_i | input | 1 | Soft reset, behaves as the system reset for the divider |
| cnt_en_i | input | 1 | Count enable; low freezes the divider |
| src_sel_i | input | 2 | Source select code |
| div_val_i | input | 12 | Divide value N; the ratio is N+1 |
| baud_o | output | 1 | Divided output clock |

## Verification
A counter that reloads from the wrong value, or one that misses an edge polarity, shows up at the port within one output period. It appears as a high or low time that differs from (N+1) source half-periods. Odd ratios expose a one-sided edge count most clearly, because that fault breaks the symmetry between the high and low times. A controller stuck in RUN during a hold shows a toggle within N+1 half-periods of the hold starting. A divide value captured before the reload appears as a wrong length for the half-period during which the write was made.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2
    } bg_state_e;

endpackage

// File: rtl/baud_gen_edge.sv
// Synchronizes every candidate source, picks one, and pulses on either edge.
module baud_gen_edge #(
    parameter int NUM_SRC     = 3,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               src_ok_o,
    output logic               tick_o
);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_SRC);

    logic [NUM_SRC-1:0] synced;
    logic               cur;
    logic               prev_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], src_i[g]};
        end
        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    assign src_ok_o = (sel_i < SEL_LIMIT);

    always_comb begin
        cur = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) cur = synced[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign tick_o = cur ^ prev_q;

    // R5: a reserved code held for two cycles yields no edge pulse
    a_r5_no_tick_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ok_o && !$past(src_ok_o)) |-> !tick_o);

endmodule

// File: rtl/baud_gen_core.sv
// Three-state controller plus the reloadable down counter and output toggle.
module baud_gen_core
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             cnt_en_i,
    input  logic             src_ok_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             out_o
);
    bg_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             out_q;
    logic             go;

    assign go = cnt_en_i && src_ok_i;

    always_comb begin
        state_d = state_q;
        if (soft_rst_i) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = go ? ST_RUN : ST_HOLD;
                ST_RUN:   if (!go) state_d = ST_HOLD;
                ST_HOLD:  if (go)  state_d = ST_RUN;
                default:  state_d = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            cnt_q <= '0;
        end else if (soft_rst_i || state_q == ST_RESET) begin
            out_q <= 1'b1;
            cnt_q <= div_i;
        end else if (state_q == ST_RUN && tick_i) begin
            if (cnt_q == '0) begin
                out_q <= ~out_q;
                cnt_q <= div_i;
            end else begin
                cnt_q <= cnt_q - DIV_W'(1);
            end
        end
    end

    assign out_o = out_q;

    // R1: soft reset forces the output high on the next cycle
    a_r1_soft_high: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> out_q);

    // R6: no output movement while held
    a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !soft_rst_i) |=> $stable(out_q));

    // R2: an output change must come from a counted edge at terminal count
    a_r2_toggle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_q) && !$past(soft_rst_i)) |-> $past(tick_i && cnt_q == '0));

    // R7: reload takes the divide value present at the reload edge
    a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && cnt_q == '0 && !soft_rst_i)
            |=> (cnt_q == $past(div_i)));

endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
    parameter int DIV_W       = 12,
    parameter int SEL_W       = 2,
    parameter int NUM_SRC     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_int_i,
    input  logic             src_ext1_i,
    input  logic             src_ext2_i,
    input  logic             soft_rst_i,
    input  logic             cnt_en_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic [DIV_W-1:0] div_val_i,
    output logic             baud_o
);
    logic [NUM_SRC-1:0] src_vec;
    logic               src_ok;
    logic               tick;

    assign src_vec = NUM_SRC'({src_ext2_i, src_ext1_i, src_int_i});

    baud_gen_edge #(
        .NUM_SRC    (NUM_SRC),
        .SEL_W      (SEL_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_vec),
        .sel_i   (src_sel_i),
        .src_ok_o(src_ok),
        .tick_o  (tick)
    );

    baud_gen_core #(
        .DIV_W(DIV_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst_i(soft_rst_i),
        .cnt_en_i  (cnt_en_i),
        .src_ok_i  (src_ok),
        .tick_i    (tick),
        .div_i     (div_val_i),
        .out_o     (baud_o)
    );

endmodule

// File: tb/baud_gen_bench.sv
`timescale 1ns/1ps
module baud_gen_bench;
    localparam int H_INT  = 2;
    localparam int H_EXT1 = 3;
    localparam int H_EXT2 = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_int = 1'b0, src_ext1 = 1'b0, src_ext2 = 1'b0;
    logic        soft_rst = 1'b0, cnt_en = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic [11:0] div = 12'd0;
    logic        baud;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    initial forever begin repeat (H_INT)  @(negedge clk); src_int  = ~src_int;  end
    initial forever begin repeat (H_EXT1) @(negedge clk); src_ext1 = ~src_ext1; end
    initial forever begin repeat (H_EXT2) @(negedge clk); src_ext2 = ~src_ext2; end

    baud_gen u_baud_gen (
        .clk(clk), .rst_n(rst_n), .src_int_i(src_int), .src_ext1_i(src_ext1),
        .src_ext2_i(src_ext2), .soft_rst_i(soft_rst), .cnt_en_i(cnt_en),
        .src_sel_i(sel), .div_val_i(div), .baud_o(baud)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        @(negedge clk);
        while (baud !== 1'b0) @(negedge clk);
        while (baud !== 1'b1) @(negedge clk);
        hi = 0;
        while (baud === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (baud === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic restart(input logic [11:0] n, input logic [1:0] s);
        @(negedge clk);
        div = n; sel = s; soft_rst = 1'b1;
        repeat (3) @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic run_len(output int len);
        logic v;
        v = baud;
        len = 1;
        @(negedge clk);
        while (baud === v) begin len++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi, lo, chg, len;
        logic v;
        logic [11:0] nlist [9];
        nlist = '{12'd0, 12'd1, 12'd2, 12'd3, 12'd4, 12'd5, 12'd6, 12'd7, 12'hFFF};

        repeat (5) @(negedge clk);
        check("R1 output high in system reset", int'(baud), 1);
        rst_n = 1'b1;

        // soft reset holds output high over many source edges
        @(negedge clk); soft_rst = 1'b1; chg = 0;
        repeat (40) begin @(negedge clk); if (baud !== 1'b1) chg++; end
        check("R1 output high during soft reset", chg, 0);
        soft_rst = 1'b0;

        // R2 / R3 sweep over even and odd ratios, including 0 and 0xFFF
        foreach (nlist[k]) begin
            restart(nlist[k], 2'd0);
            measure(hi, lo);
            check("R3 high time", hi, (int'(nlist[k]) + 1) * H_INT);
            check("R3 low time", lo, (int'(nlist[k]) + 1) * H_INT);
            check("R2 period", hi + lo, 2 * (int'(nlist[k]) + 1) * H_INT);
        end

        // R4 source selection
        restart(12'd2, 2'd1);
        measure(hi, lo);
        check("R4 ext1 period", hi + lo, 2 * 3 * H_EXT1);
        restart(12'd4, 2'd2);
        measure(hi, lo);
        check("R4 ext2 period", hi + lo, 2 * 5 * H_EXT2);
        restart(12'd1, 2'd0);
        measure(hi, lo);
        check("R4 internal period", hi + lo, 2 * 2 * H_INT);

        // R6 enable low freezes, then resumes
        restart(12'd2, 2'd0);
        measure(hi, lo);
        cnt_en = 1'b0;
        repeat (2) @(negedge clk);
        v = baud; chg = 0;
        repeat (100) begin @(negedge clk); if (baud !== v) chg++; end
        check("R6 output frozen with enable low", chg, 0);
        cnt_en = 1'b1;
        measure(hi, lo);
        check("R6 period after resume", hi + lo, 2 * 3 * H_INT);

        // R5 reserved source code freezes, then resumes
        restart(12'd3, 2'd0);
        measure(hi, lo);
        sel = 2'd3;
        repeat (2) @(negedge clk);
        v = baud; chg = 0;
        repeat (100) begin @(negedge clk); if (baud !== v) chg++; end
        check("R5 output frozen on reserved code", chg, 0);
        sel = 2'd0;
        measure(hi, lo);
        check("R5 period after leaving reserved code", hi + lo, 2 * 4 * H_INT);

        // R7 divide change applies from the next reload
        restart(12'd3, 2'd0);
        measure(hi, lo);
        v = baud;
        while (baud === v) @(negedge clk);
        div = 12'd1;
        run_len(len);
        check("R7 half-period in progress keeps old ratio", len, 4 * H_INT);
        run_len(len);
        check("R7 next half-period uses new ratio", len, 2 * H_INT);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule